// File: doc/BRIEF.md
# Alternating Dual-Reload One-Shot Timer

This block times one-shot pulses for one phase of a PWM generator. A strobe from the carrier counter, issued each time that counter passes zero, starts a pulse. The pulse length comes from one of two reload values. When triangular modulation is chosen and the two-register option is switched on, successive strobes take their length from the two registers in turn. This yields the rising and falling halves of a triangular-modulated edge.

The pulse counts down one step per clock. In its final cycle the block raises a one-cycle end strobe, which the phase output stage uses to shift its pattern register. A select flag shows which register set the current pulse, so neighbouring logic can tell the two halves of the carrier period apart. A new strobe during a running pulse restarts the count at once.

Top module: `dual_reload_oneshot`

## Requirements
- R1: After reset, `pulse_o`, `end_o` and `sel_o` are all 0.
- R2: Alternation is enabled only when `mod_sel_i` = 0 (triangular) and `dual_en_i` = 1. In any other combination, every trigger loads `reload_a_i` and sets `sel_o` to 0.
- R3: With alternation enabled, successive triggers load `reload_a_i`, then `reload_b_i`, and so on. `sel_o` is 0 for a pulse timed by `reload_a_i` and 1 for one timed by `reload_b_i`.
- R4: The first trigger after reset uses `reload_a_i`. So does the first trigger after alternation has been disabled for at least one cycle.
- R5: `sel_o` changes only at a clock edge that samples `trig_i` high. It holds its value through the pulse and afterwards.
- R6: A trigger sampled at edge E0 with loaded value N sets `pulse_o` high from E0 for exactly N+1 cycles.
- R7: `end_o` is high for exactly one cycle, and that cycle is the last `pulse_o` cycle. A loaded value of 0 gives `end_o` in the cycle right after the trigger edge.
- R8: A trigger during a running pulse restarts the count from the next register in sequence. The abandoned pulse gives no `end_o`.
- R9: Without triggers, `pulse_o` and `end_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Carrier-zero strobe, one cycle |
| reload_a_i | input | CNT_WIDTH | First reload value |
| reload_b_i | input | CNT_WIDTH | Second reload value |
| mod_sel_i | input | 1 | Modulation mode, 0 = triangular |
| dual_en_i | input | 1 | Two-register option enable |
| pulse_o | output | 1 | One-shot pulse active |
| end_o | output | 1 | End-of-pulse strobe |
| sel_o | output | 1 | Register that set the current pulse (0 = A, 1 = B) |

## Verification
Take E0 as the edge that samples the trigger. `pulse_o` and `sel_o` take their new values just after E0. `end_o` is due N cycles later, in the (N+1)th pulse cycle, because it is decoded from the counter state without an added register. The monitor samples one nanosecond after each rising edge, when `trig_i` still holds the value that edge sampled. It restarts its length count on each sampled trigger and compares the measured length and select flag with the queued expectation when `end_o` is seen. The driver queues an expectation only for pulses that should complete, so any `end_o` from an abandoned pulse, or during idle time, finds an empty queue and is reported.

// File: rtl/dro_pkg.sv
package dro_pkg;
   typedef enum logic {
      SEL_A = 1'b0,
      SEL_B = 1'b1
   } reload_sel_e;

   localparam int unsigned MAX_CNT_WIDTH = 32;
endpackage

// File: rtl/dro_reload_sel.sv
module dro_reload_sel
   import dro_pkg::*;
#(
   parameter int unsigned CNT_WIDTH = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trig_i,
   input  logic                 dual_i,
   input  logic [CNT_WIDTH-1:0] val_a_i,
   input  logic [CNT_WIDTH-1:0] val_b_i,
   output logic [CNT_WIDTH-1:0] load_val_o,
   output logic                 sel_o
);
   reload_sel_e next_q;
   reload_sel_e cur_q;
   reload_sel_e use_sel;

   // register chosen for a trigger in this cycle
   assign use_sel    = dual_i ? next_q : SEL_A;
   assign load_val_o = (use_sel == SEL_B) ? val_b_i : val_a_i;
   assign sel_o      = (cur_q == SEL_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q <= SEL_A;
         cur_q  <= SEL_A;
      end else begin
         if (!dual_i) begin
            next_q <= SEL_A;
         end else if (trig_i) begin
            next_q <= (next_q == SEL_A) ? SEL_B : SEL_A;
         end
         if (trig_i) begin
            cur_q <= use_sel;
         end
      end
   end
endmodule

// File: rtl/dro_down_counter.sv
module dro_down_counter #(
   parameter int unsigned CNT_WIDTH = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_i,
   input  logic [CNT_WIDTH-1:0] load_val_i,
   output logic                 active_o,
   output logic                 done_o
);
   localparam logic [CNT_WIDTH-1:0] CNT_ZERO = '0;
   localparam logic [CNT_WIDTH-1:0] CNT_ONE  = CNT_WIDTH'(1);

   logic [CNT_WIDTH-1:0] cnt_q;
   logic                 active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= CNT_ZERO;
         active_q <= 1'b0;
      end else if (load_i) begin
         cnt_q    <= load_val_i;
         active_q <= 1'b1;
      end else if (active_q) begin
         if (cnt_q == CNT_ZERO) begin
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - CNT_ONE;
         end
      end
   end

   assign active_o = active_q;
   assign done_o   = active_q && (cnt_q == CNT_ZERO);
endmodule

// File: rtl/dual_reload_oneshot.sv
module dual_reload_oneshot
   import dro_pkg::*;
#(
   parameter int unsigned CNT_WIDTH    = 16,
   parameter bit          DUAL_SUPPORT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trig_i,
   input  logic [CNT_WIDTH-1:0] reload_a_i,
   input  logic [CNT_WIDTH-1:0] reload_b_i,
   input  logic                 mod_sel_i,
   input  logic                 dual_en_i,
   output logic                 pulse_o,
   output logic                 end_o,
   output logic                 sel_o
);
   logic                 dual_act;
   logic [CNT_WIDTH-1:0] load_val;

   generate
      if (CNT_WIDTH < 1 || CNT_WIDTH > MAX_CNT_WIDTH) begin : g_bad_width
         $error("dual_reload_oneshot: CNT_WIDTH out of range");
      end

      if (DUAL_SUPPORT) begin : g_dual
         assign dual_act = !mod_sel_i && dual_en_i;
      end else begin : g_single
         assign dual_act = 1'b0;
      end
   endgenerate

   dro_reload_sel #(
      .CNT_WIDTH (CNT_WIDTH)
   ) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (trig_i),
      .dual_i     (dual_act),
      .val_a_i    (reload_a_i),
      .val_b_i    (reload_b_i),
      .load_val_o (load_val),
      .sel_o      (sel_o)
   );

   dro_down_counter #(
      .CNT_WIDTH (CNT_WIDTH)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (trig_i),
      .load_val_i (load_val),
      .active_o   (pulse_o),
      .done_o     (end_o)
   );
endmodule

// File: rtl/dro_checker.sv
module dro_checker (
   input logic clk,
   input logic rst_n,
   input logic trig_i,
   input logic mod_sel_i,
   input logic dual_en_i,
   input logic pulse_o,
   input logic end_o,
   input logic sel_o
);
   // R7: end strobe only inside a pulse
   assert_end_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      end_o |-> pulse_o);

   // R7: pulse closes after its end strobe unless retriggered
   assert_pulse_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (end_o && !trig_i) |=> (!pulse_o && !end_o));

   // R6: a sampled trigger always opens a pulse
   assert_trig_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i |=> pulse_o);

   // R9: a pulse only begins after a trigger
   assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_o && !trig_i) |=> !pulse_o);

   // R5: select flag moves only on triggers
   assert_sel_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_i |=> $stable(sel_o));

   // R2: single-register operation always reports register A
   assert_single_uses_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !(!mod_sel_i && dual_en_i)) |=> !sel_o);
endmodule

bind dual_reload_oneshot dro_checker u_dro_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig_i    (trig_i),
   .mod_sel_i (mod_sel_i),
   .dual_en_i (dual_en_i),
   .pulse_o   (pulse_o),
   .end_o     (end_o),
   .sel_o     (sel_o)
);

// File: tb/dual_reload_oneshot_tb_top.sv
`timescale 1ns/1ps
module dual_reload_oneshot_tb_top;
   localparam int unsigned W = 16;

   typedef struct {
      logic  sel;
      int    len;
      string req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         trig = 1'b0;
   logic [W-1:0] ra = '0;
   logic [W-1:0] rb = '0;
   logic         mod_sel = 1'b0;
   logic         dual_en = 1'b0;
   logic         pulse, endp, sel;

   int   n_chk = 0;
   int   n_fail = 0;
   logic nxt = 1'b0;
   int   plen = 0;
   exp_t q[$];

   always #2 clk = ~clk;

   dual_reload_oneshot #(.CNT_WIDTH(W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_i     (trig),
      .reload_a_i (ra),
      .reload_b_i (rb),
      .mod_sel_i  (mod_sel),
      .dual_en_i  (dual_en),
      .pulse_o    (pulse),
      .end_o      (endp),
      .sel_o      (sel)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic m, input logic e);
      @(negedge clk);
      mod_sel = m;
      dual_en = e;
      if (!(!m && e)) nxt = 1'b0;
   endtask

   // one trigger; the model chooses the register, push=0 for an abandoned pulse
   task automatic fire(input int a, input int b, input bit push, input string req);
      logic dual, s;
      exp_t it;
      @(negedge clk);
      ra = W'(a);
      rb = W'(b);
      trig = 1'b1;
      dual = !mod_sel && dual_en;
      s = dual ? nxt : 1'b0;
      nxt = dual ? ~nxt : 1'b0;
      if (push) begin
         it.sel = s;
         it.len = (s ? b : a) + 1;
         it.req = req;
         q.push_back(it);
      end
      @(negedge clk);
      trig = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: 1 ns after each rising edge, trig still shows the sampled value
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (trig) plen = 0;
         if (pulse) plen++;
         if (endp) begin
            if (q.size() == 0) begin
               n_chk++;
               n_fail++;
               $display("FAIL R8/R9 actual=end_o expected=no end strobe");
            end else begin
               exp_t e;
               e = q.pop_front();
               check({e.req, " sel_o"}, int'(sel), int'(e.sel));
               check({e.req, " R6 pulse length"}, plen, e.len);
            end
         end
      end
   end

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 pulse_o", int'(pulse), 0);
      check("R1 end_o", int'(endp), 0);
      check("R1 sel_o", int'(sel), 0);

      // R2: sawtooth mode ignores the enable
      set_mode(1'b1, 1'b1);
      fire(5, 9, 1, "R2"); drain();
      fire(5, 9, 1, "R2"); drain();
      // R2: triangular mode with the option off
      set_mode(1'b0, 1'b0);
      fire(3, 8, 1, "R2"); drain();
      fire(3, 8, 1, "R2"); drain();

      // R3 / R4: alternation from register A
      set_mode(1'b0, 1'b1);
      fire(4, 7, 1, "R4"); drain();
      fire(4, 7, 1, "R3"); drain();
      fire(4, 7, 1, "R3"); drain();
      // R7: zero reload ends in the first pulse cycle
      fire(0, 0, 1, "R7"); drain();
      fire(0, 0, 1, "R7"); drain();
      // R8: restart mid-pulse
      fire(12, 12, 0, "R8");
      repeat (2) @(negedge clk);
      fire(6, 2, 1, "R8"); drain();
      // R4: leave and re-enter alternation
      set_mode(1'b0, 1'b0);
      set_mode(1'b0, 1'b1);
      fire(3, 11, 1, "R4"); drain();
      fire(3, 11, 1, "R3"); drain();

      // R9: idle window, no pulse
      repeat (40) @(negedge clk);
      check("R9 pulse_o idle", int'(pulse), 0);
      check("R9 end_o idle", int'(endp), 0);
      check("R5 sel_o held", int'(sel), 1);
      check("queue empty", q.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule